// File: doc/BRIEF.md
# Exception Entry Unit

This unit carries out the architectural state change that happens when a processor takes a pending exception. A request carries an exception number, an error-code bitfield that says why the fault happened, the current 32-bit machine state word and the next-instruction address. From these inputs the unit computes five results:

- the handler address;
- the return address to save;
- the state word to save;
- the data-fault status word;
- the new machine state.

It then registers the results and raises a one-cycle flush request so that translation caches can be emptied.

Some requests are not taken. An external or decrementer interrupt is deferred when interrupts are masked. A floating-point program exception is dropped when floating-point exceptions are disabled. A machine check that arrives while machine checks are disabled is reported as fatal. In each of these three cases no architectural register changes.

The unit accepts one request, spends one cycle evaluating it and reports exactly one outcome pulse. It cannot accept another request until it is idle again.

Top module: `exc_entry_unit`

## Requirements

Field positions used below. All bit numbers count from bit 0 as the least significant bit.

State word bits:

| Bit | Meaning |
|---|---|
| 18 | power |
| 16 | interrupt little-endian |
| 15 | external enable |
| 14 | privilege |
| 13 | FP |
| 12 | machine-check enable |
| 11 | FP-enable A |
| 10 | single-step |
| 9 | branch-trace |
| 8 | FP-enable B |
| 5 | instruction translation |
| 4 | data translation |
| 1 | recoverable |
| 0 | little-endian |

Error-code bits:

| Bit | Meaning |
|---|---|
| 0 | miss |
| 1 | protection |
| 2 | unsupported |
| 3 | direct-store |
| 4 | store |
| 5 | no-execute |
| 6 | guarded |

For a program exception, error-code bits [1:0] give the kind: 0 = floating point, 1 = illegal, 2 = privileged, 3 = trap.

Exception numbers:

| Number | Exception |
|---|---|
| 1 | reset |
| 2 | machine check |
| 3 | data fault |
| 4 | instruction fault |
| 5 | external |
| 6 | alignment |
| 7 | program |
| 8 | FP unavailable |
| 9 | decrementer |
| 12 | syscall |
| 13 | trace |

Any other number is taken with no class-specific handling.

- R1: On a taken exception, the handler address becomes the exception number shifted left by 8, zero-extended.
- R2: Exception 5 or 9 with state bit 15 = 0 gives a deferred pulse. No output register changes and no flush is raised.
- R3: For exception 3, the fault status word is rebuilt from zero:
  - bit 30 if the error code has miss;
  - otherwise bit 27 if it has protection;
  - otherwise bit 31 if it has unsupported, together with bit 26 if it also has direct-store;
  - bit 25 is added whenever the error code has store.
- R4: For exception 4, the saved state is the incoming word with bits [31:16] cleared, and then:
  - bit 30 set on miss;
  - otherwise bit 28 set on no-execute, guarded or direct-store;
  - otherwise bit 27 set.
- R5: For exception 7, the saved state has bits [31:16] cleared, then bit 16 set, plus bit 20, 19, 18 or 17 for kind 0, 1, 2 or 3. Kind 0 with state bits 11 and 8 both 0 gives a dropped pulse and changes nothing.
- R6: Exceptions 6, 7 and 8 save the next address minus 4 as the return address. Every other taken exception saves the next address.
- R7: The new machine state:
  - clears bits 18, 15, 14, 13, 11, 10, 9, 8, 5, 4 and 1;
  - copies bit 16 into bit 0;
  - keeps every other bit.
- R8: Exception 2 with state bit 12 = 0 gives a fatal pulse and changes nothing. With bit 12 = 1, the new state also clears bit 12, while the saved state keeps it.
- R9: For classes other than 3, 4 and 7, the saved state equals the incoming word. For class 3, the saved state is the incoming word with bits [31:16] cleared. The fault status word changes only on exception 3.
- R10: Every accepted request yields exactly one of the four outcome pulses (taken, deferred, dropped, fatal). The flush request is a one-cycle pulse that coincides with each taken pulse.
- R11: Timing of the request handshake:
  - Ready is high when idle.
  - A request is accepted on an edge where valid and ready are both high. Ready is then low for the following cycle.
  - The outcome and the registered results appear after the second edge following acceptance.
  - After reset every output is 0 and ready is 1.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_num | input | NUM_W | Exception number |
| req_err | input | 7 | Error-code bitfield |
| req_state | input | 32 | Current machine state word |
| req_nia | input | ADDR_W | Next-instruction address |
| req_ready | output | 1 | Unit idle, request will be accepted |
| ent_taken | output | 1 | Exception taken pulse |
| ent_deferred | output | 1 | Masked interrupt left pending pulse |
| ent_dropped | output | 1 | Disabled FP program exception ignored pulse |
| ent_fatal | output | 1 | Machine check while disabled pulse |
| flush_req | output | 1 | Translation flush request pulse |
| handler_addr | output | ADDR_W | Handler address |
| srr_ret | output | ADDR_W | Saved return address |
| srr_state | output | 32 | Saved machine state |
| fault_status | output | 32 | Data-fault status word |
| cur_state | output | 32 | Updated machine state |

## Verification

The timing assertions rely on one property of the inputs: the exception number and the next address sampled on the accepting edge are exactly what `$past(...,2)` sees when the outcome pulse is checked. This holds only because acceptance and result are always exactly two edges apart and the unit refuses requests while busy. The stimulus drives every request on a falling edge and drops valid one cycle later, so inputs never change near a sampling edge. Some requests hold valid for three cycles, so a request presented while the unit is busy is refused and then accepted again. Numbers are drawn from the listed classes plus arbitrary values, and the enable bits in the state word are randomised so that deferred, dropped and fatal outcomes all occur.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int STATE_W = 32;
    localparam int ERR_W   = 7;

    // machine state word fields
    localparam int B_POW = 18;
    localparam int B_ILE = 16;
    localparam int B_EE  = 15;
    localparam int B_PR  = 14;
    localparam int B_FP  = 13;
    localparam int B_ME  = 12;
    localparam int B_FEA = 11;
    localparam int B_SE  = 10;
    localparam int B_BE  = 9;
    localparam int B_FEB = 8;
    localparam int B_IR  = 5;
    localparam int B_DR  = 4;
    localparam int B_RI  = 1;
    localparam int B_LE  = 0;

    // exception numbers
    localparam int V_RESET = 1;
    localparam int V_MCHK  = 2;
    localparam int V_DFLT  = 3;
    localparam int V_IFLT  = 4;
    localparam int V_EXT   = 5;
    localparam int V_ALGN  = 6;
    localparam int V_PROG  = 7;
    localparam int V_FPUN  = 8;
    localparam int V_DEC   = 9;

    // error-code bits
    localparam int F_MISS   = 0;
    localparam int F_PROT   = 1;
    localparam int F_UNSUP  = 2;
    localparam int F_DIRECT = 3;
    localparam int F_STORE  = 4;
    localparam int F_NOEXEC = 5;
    localparam int F_GUARD  = 6;

    // cause bits written into status / saved state
    localparam int C_UNSUP  = 31;
    localparam int C_MISS   = 30;
    localparam int C_NOX    = 28;
    localparam int C_PROT   = 27;
    localparam int C_DIRECT = 26;
    localparam int C_STORE  = 25;
    localparam int C_PFP    = 20;
    localparam int C_PILL   = 19;
    localparam int C_PPRIV  = 18;
    localparam int C_PTRAP  = 17;
    localparam int C_PROG   = 16;

    typedef enum logic [1:0] {
        OUT_TAKE  = 2'd0,
        OUT_DEFER = 2'd1,
        OUT_DROP  = 2'd2,
        OUT_FATAL = 2'd3
    } outcome_e;
endpackage

// File: rtl/exc_cause_enc.sv
module exc_cause_enc
    import exc_pkg::*;
#(
    parameter int NUM_W = 8
) (
    input  logic [NUM_W-1:0]   num,
    input  logic [ERR_W-1:0]   err,
    input  logic [STATE_W-1:0] st,
    output outcome_e           outcome,
    output logic [STATE_W-1:0] saved,
    output logic [STATE_W-1:0] status,
    output logic               status_wr,
    output logic               ret_cur
);
    localparam logic [STATE_W-1:0] LOW_HALF = STATE_W'(32'h0000_FFFF);

    logic is_masked_irq;
    logic fp_disabled;

    always_comb begin
        is_masked_irq = ((num == NUM_W'(V_EXT)) || (num == NUM_W'(V_DEC))) && !st[B_EE];
        fp_disabled   = !st[B_FEA] && !st[B_FEB];
    end

    always_comb begin
        outcome   = OUT_TAKE;
        saved     = st;
        status    = '0;
        status_wr = 1'b0;
        ret_cur   = 1'b0;
        if (is_masked_irq) begin
            outcome = OUT_DEFER;
        end else if (num == NUM_W'(V_MCHK) && !st[B_ME]) begin
            outcome = OUT_FATAL;
        end else begin
            case (num)
                NUM_W'(V_DFLT): begin
                    saved     = st & LOW_HALF;
                    status_wr = 1'b1;
                    if (err[F_MISS]) begin
                        status[C_MISS] = 1'b1;
                    end else if (err[F_PROT]) begin
                        status[C_PROT] = 1'b1;
                    end else if (err[F_UNSUP]) begin
                        status[C_UNSUP]  = 1'b1;
                        status[C_DIRECT] = err[F_DIRECT];
                    end
                    status[C_STORE] = err[F_STORE];
                end
                NUM_W'(V_IFLT): begin
                    saved = st & LOW_HALF;
                    if (err[F_MISS])
                        saved[C_MISS] = 1'b1;
                    else if (err[F_NOEXEC] || err[F_GUARD] || err[F_DIRECT])
                        saved[C_NOX] = 1'b1;
                    else
                        saved[C_PROT] = 1'b1;
                end
                NUM_W'(V_PROG): begin
                    ret_cur = 1'b1;
                    saved   = st & LOW_HALF;
                    saved[C_PROG] = 1'b1;
                    case (err[1:0])
                        2'd0: saved[C_PFP]   = 1'b1;
                        2'd1: saved[C_PILL]  = 1'b1;
                        2'd2: saved[C_PPRIV] = 1'b1;
                        default: saved[C_PTRAP] = 1'b1;
                    endcase
                    if (err[1:0] == 2'd0 && fp_disabled)
                        outcome = OUT_DROP;
                end
                NUM_W'(V_ALGN), NUM_W'(V_FPUN): ret_cur = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/exc_state_upd.sv
module exc_state_upd
    import exc_pkg::*;
(
    input  logic [STATE_W-1:0] st,
    input  logic               clr_me,
    output logic [STATE_W-1:0] nst
);
    localparam logic [STATE_W-1:0] CLR_MASK =
        (STATE_W'(1) << B_POW) | (STATE_W'(1) << B_EE)  | (STATE_W'(1) << B_PR) |
        (STATE_W'(1) << B_FP)  | (STATE_W'(1) << B_FEA) | (STATE_W'(1) << B_SE) |
        (STATE_W'(1) << B_BE)  | (STATE_W'(1) << B_FEB) | (STATE_W'(1) << B_IR) |
        (STATE_W'(1) << B_DR)  | (STATE_W'(1) << B_RI);

    always_comb begin
        nst = st & ~CLR_MASK;
        if (clr_me)
            nst[B_ME] = 1'b0;
        nst[B_LE] = st[B_ILE];
    end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int NUM_W  = 8,
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [NUM_W-1:0]   req_num,
    input  logic [ERR_W-1:0]   req_err,
    input  logic [STATE_W-1:0] req_state,
    input  logic [ADDR_W-1:0]  req_nia,
    output logic               req_ready,
    output logic               ent_taken,
    output logic               ent_deferred,
    output logic               ent_dropped,
    output logic               ent_fatal,
    output logic               flush_req,
    output logic [ADDR_W-1:0]  handler_addr,
    output logic [ADDR_W-1:0]  srr_ret,
    output logic [STATE_W-1:0] srr_state,
    output logic [STATE_W-1:0] fault_status,
    output logic [STATE_W-1:0] cur_state
);
    localparam int VEC_SHIFT = 8;

    typedef struct packed {
        logic               busy;
        logic [NUM_W-1:0]   num;
        logic [ERR_W-1:0]   err;
        logic [STATE_W-1:0] st;
        logic [ADDR_W-1:0]  nia;
        logic               taken;
        logic               deferred;
        logic               dropped;
        logic               fatal;
        logic               flush;
        logic [ADDR_W-1:0]  handler;
        logic [ADDR_W-1:0]  ret;
        logic [STATE_W-1:0] saved;
        logic [STATE_W-1:0] status;
        logic [STATE_W-1:0] mstate;
    } regs_t;

    regs_t r_q, r_d;

    outcome_e           enc_outcome;
    logic [STATE_W-1:0] enc_saved;
    logic [STATE_W-1:0] enc_status;
    logic               enc_status_wr;
    logic               enc_ret_cur;
    logic [STATE_W-1:0] upd_state;

    exc_cause_enc #(.NUM_W(NUM_W)) u_enc (
        .num       (r_q.num),
        .err       (r_q.err),
        .st        (r_q.st),
        .outcome   (enc_outcome),
        .saved     (enc_saved),
        .status    (enc_status),
        .status_wr (enc_status_wr),
        .ret_cur   (enc_ret_cur)
    );

    exc_state_upd u_upd (
        .st     (r_q.st),
        .clr_me (r_q.num == NUM_W'(V_MCHK)),
        .nst    (upd_state)
    );

    always_comb begin
        r_d          = r_q;
        r_d.taken    = 1'b0;
        r_d.deferred = 1'b0;
        r_d.dropped  = 1'b0;
        r_d.fatal    = 1'b0;
        r_d.flush    = 1'b0;
        if (r_q.busy) begin
            case (enc_outcome)
                OUT_DEFER: r_d.deferred = 1'b1;
                OUT_DROP:  r_d.dropped  = 1'b1;
                OUT_FATAL: r_d.fatal    = 1'b1;
                default: begin
                    r_d.taken   = 1'b1;
                    r_d.flush   = 1'b1;
                    r_d.handler = ADDR_W'({r_q.num, {VEC_SHIFT{1'b0}}});
                    r_d.ret     = enc_ret_cur ? (r_q.nia - ADDR_W'(4)) : r_q.nia;
                    r_d.saved   = enc_saved;
                    r_d.mstate  = upd_state;
                    if (enc_status_wr)
                        r_d.status = enc_status;
                end
            endcase
        end
        r_d.busy = req_valid && !r_q.busy;
        if (req_valid && !r_q.busy) begin
            r_d.num = req_num;
            r_d.err = req_err;
            r_d.st  = req_state;
            r_d.nia = req_nia;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign req_ready    = !r_q.busy;
    assign ent_taken    = r_q.taken;
    assign ent_deferred = r_q.deferred;
    assign ent_dropped  = r_q.dropped;
    assign ent_fatal    = r_q.fatal;
    assign flush_req    = r_q.flush;
    assign handler_addr = r_q.handler;
    assign srr_ret      = r_q.ret;
    assign srr_state    = r_q.saved;
    assign fault_status = r_q.status;
    assign cur_state    = r_q.mstate;

    // R11: busy never lasts more than one cycle
    a_r11_busy_one: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    // R10: at most one outcome per cycle
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ent_taken, ent_deferred, ent_dropped, ent_fatal}));

    // R10: flush is a single-cycle pulse
    a_r10_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !flush_req);

    // R1: handler derived from the number accepted two edges earlier
    a_r1_handler: assert property (@(posedge clk) disable iff (!rst_n)
        ent_taken |-> handler_addr == ADDR_W'({$past(req_num, 2), {VEC_SHIFT{1'b0}}}));

    // R7: interrupts and privilege are off after entry
    a_r7_state_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ent_taken |-> (!cur_state[B_EE] && !cur_state[B_PR] && !cur_state[B_IR] && !cur_state[B_DR]));

    // R2: deferred interrupts leave state and return address alone
    a_r2_defer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ent_deferred |-> ($stable(cur_state) && $stable(srr_ret) && !flush_req));

    // R6: program exceptions return to the faulting instruction
    a_r6_prog_current: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_taken && $past(req_num, 2) == NUM_W'(V_PROG)) |-> srr_ret == $past(req_nia, 2) - ADDR_W'(4));
endmodule

// File: tb/sim_exc_entry_unit.sv
module sim_exc_entry_unit;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_num = '0;
    logic [6:0]  req_err = '0;
    logic [31:0] req_state = '0;
    logic [31:0] req_nia = '0;
    logic        req_ready, ent_taken, ent_deferred, ent_dropped, ent_fatal, flush_req;
    logic [31:0] handler_addr, srr_ret, srr_state, fault_status, cur_state;

    exc_entry_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_num(req_num),
        .req_err(req_err), .req_state(req_state), .req_nia(req_nia),
        .req_ready(req_ready), .ent_taken(ent_taken), .ent_deferred(ent_deferred),
        .ent_dropped(ent_dropped), .ent_fatal(ent_fatal), .flush_req(flush_req),
        .handler_addr(handler_addr), .srr_ret(srr_ret), .srr_state(srr_state),
        .fault_status(fault_status), .cur_state(cur_state)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // behavioural reference
    bit          m_busy;
    logic [7:0]  m_num;
    logic [6:0]  m_err;
    logic [31:0] m_st, m_nia;
    bit          m_taken, m_def, m_drop, m_fatal;
    logic [31:0] m_handler, m_ret, m_saved, m_status, m_state;

    task automatic model_step();
        logic [31:0] sv, ns, stat;
        bit cur;
        sv = m_st;
        cur = 0;
        if ((m_num == 8'd5 || m_num == 8'd9) && !m_st[15]) begin
            m_def = 1;
        end else if (m_num == 8'd7 && m_err[1:0] == 2'd0 && !m_st[11] && !m_st[8]) begin
            m_drop = 1;
        end else if (m_num == 8'd2 && !m_st[12]) begin
            m_fatal = 1;
        end else begin
            m_taken = 1;
            if (m_num == 8'd3) begin
                sv = m_st & 32'h0000FFFF;
                stat = 32'h0;
                if (m_err[0]) stat = 32'h4000_0000;
                else if (m_err[1]) stat = 32'h0800_0000;
                else if (m_err[2]) stat = m_err[3] ? 32'h8400_0000 : 32'h8000_0000;
                if (m_err[4]) stat = stat | 32'h0200_0000;
                m_status = stat;
            end else if (m_num == 8'd4) begin
                sv = m_st & 32'h0000FFFF;
                if (m_err[0]) sv = sv | 32'h4000_0000;
                else if (m_err[5] || m_err[6] || m_err[3]) sv = sv | 32'h1000_0000;
                else sv = sv | 32'h0800_0000;
            end else if (m_num == 8'd7) begin
                cur = 1;
                sv = (m_st & 32'h0000FFFF) | 32'h0001_0000;
                case (m_err[1:0])
                    2'd0: sv = sv | 32'h0010_0000;
                    2'd1: sv = sv | 32'h0008_0000;
                    2'd2: sv = sv | 32'h0004_0000;
                    default: sv = sv | 32'h0002_0000;
                endcase
            end else if (m_num == 8'd6 || m_num == 8'd8) begin
                cur = 1;
            end
            ns = m_st & ~32'h0004_EF32;
            if (m_num == 8'd2) ns[12] = 1'b0;
            ns[0] = m_st[16];
            m_ret = cur ? m_nia - 32'd4 : m_nia;
            m_handler = {16'h0, m_num, 8'h00};
            m_saved = sv;
            m_state = ns;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_num = '0; m_err = '0; m_st = '0; m_nia = '0;
            m_taken = 0; m_def = 0; m_drop = 0; m_fatal = 0;
            m_handler = '0; m_ret = '0; m_saved = '0; m_status = '0; m_state = '0;
        end else begin
            m_taken = 0; m_def = 0; m_drop = 0; m_fatal = 0;
            if (m_busy) model_step();
            if (req_valid && !m_busy) begin
                m_num = req_num; m_err = req_err; m_st = req_state; m_nia = req_nia;
                m_busy = 1;
            end else begin
                m_busy = 0;
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            chk("R11", "ready", {31'b0, req_ready}, {31'b0, !m_busy});
            chk("R10", "taken", {31'b0, ent_taken}, {31'b0, m_taken});
            chk("R2", "deferred", {31'b0, ent_deferred}, {31'b0, m_def});
            chk("R5", "dropped", {31'b0, ent_dropped}, {31'b0, m_drop});
            chk("R8", "fatal", {31'b0, ent_fatal}, {31'b0, m_fatal});
            chk("R10", "flush", {31'b0, flush_req}, {31'b0, m_taken});
            chk("R1", "handler", handler_addr, m_handler);
            chk("R6", "return", srr_ret, m_ret);
            chk("R4", "saved state (R5 R9)", srr_state, m_saved);
            chk("R3", "status (R9)", fault_status, m_status);
            chk("R7", "state (R8)", cur_state, m_state);
        end
    end

    task automatic issue(input logic [7:0] n, input logic [6:0] e, input logic [31:0] s,
                         input logic [31:0] a, input int hold);
        @(negedge clk);
        req_valid = 1'b1; req_num = n; req_err = e; req_state = s; req_nia = a;
        repeat (hold) @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    localparam logic [31:0] ALL_ON = 32'h0001_FFFF;

    initial begin
        repeat (3) @(negedge clk);   // R11 reset state compared here
        rst_n = 1'b1;
        // R3 data faults
        issue(8'd3, 7'h11, ALL_ON, 32'h1000, 1);
        issue(8'd3, 7'h02, 32'hABCD_1234, 32'h2000, 1);
        issue(8'd3, 7'h1C, ALL_ON, 32'h3000, 1);
        issue(8'd3, 7'h04, ALL_ON, 32'h3004, 1);
        issue(8'd3, 7'h00, ALL_ON, 32'h3008, 1);
        // R4 instruction faults
        issue(8'd4, 7'h01, ALL_ON, 32'h4000, 1);
        issue(8'd4, 7'h20, ALL_ON, 32'h4004, 1);
        issue(8'd4, 7'h40, ALL_ON, 32'h4008, 1);
        issue(8'd4, 7'h08, ALL_ON, 32'h400C, 1);
        issue(8'd4, 7'h02, ALL_ON, 32'h4010, 1);
        // R5 program kinds, FP dropped when both enables are off
        issue(8'd7, 7'h00, ALL_ON & ~32'h0900, 32'h5000, 1);
        issue(8'd7, 7'h00, 32'h0000_0800, 32'h5004, 1);
        issue(8'd7, 7'h00, 32'h0000_0100, 32'h5008, 1);
        issue(8'd7, 7'h01, 32'h0, 32'h500C, 1);
        issue(8'd7, 7'h02, ALL_ON, 32'h5010, 1);
        issue(8'd7, 7'h03, ALL_ON, 32'h5014, 1);
        // R6 current-address classes and next-address classes; R9 saved state
        issue(8'd6, 7'h00, ALL_ON, 32'h6000, 1);
        issue(8'd8, 7'h00, ALL_ON, 32'h6100, 1);
        issue(8'd12, 7'h00, 32'hFFFF_FFFF, 32'h6200, 1);
        issue(8'd13, 7'h00, ALL_ON, 32'h6300, 1);
        issue(8'd1, 7'h00, 32'h0001_0000, 32'h6400, 1);
        // R2 masked interrupts deferred, unmasked taken
        issue(8'd5, 7'h00, ALL_ON & ~32'h8000, 32'h7000, 1);
        issue(8'd9, 7'h00, ALL_ON & ~32'h8000, 32'h7004, 1);
        issue(8'd5, 7'h00, ALL_ON, 32'h7008, 1);
        issue(8'd9, 7'h00, ALL_ON, 32'h700C, 1);
        // R8 machine check
        issue(8'd2, 7'h00, ALL_ON & ~32'h1000, 32'h8000, 1);
        issue(8'd2, 7'h00, ALL_ON, 32'h8004, 1);
        // R1 unusual number
        issue(8'hFF, 7'h00, ALL_ON, 32'h9000, 1);
        // R11 valid held across the busy cycle
        issue(8'd3, 7'h01, ALL_ON, 32'hA000, 3);
        issue(8'd12, 7'h00, ALL_ON, 32'hA100, 4);
        // mixed random traffic
        for (int i = 0; i < 300; i++) begin
            logic [7:0] n;
            int pick;
            pick = $urandom_range(0, 12);
            case (pick)
                0: n = 8'd1;  1: n = 8'd2;  2: n = 8'd3;  3: n = 8'd4;
                4: n = 8'd5;  5: n = 8'd6;  6: n = 8'd7;  7: n = 8'd8;
                8: n = 8'd9;  9: n = 8'd12; 10: n = 8'd13;
                default: n = 8'($urandom);
            endcase
            issue(n, 7'($urandom), $urandom, $urandom & 32'hFFFF_FFFC, $urandom_range(1, 3));
        end
        repeat (3) @(negedge clk);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end
endmodule